// File: doc/BRIEF.md
# BCD Programmable Watchdog Timer

This block is a software watchdog whose timeout is given as four BCD digits in steps of 10 ms, from 00.01 s to 99.99 s. Software writes two timeout bytes: one holds the whole seconds and the other the hundredths and tenths. A BCD down-counter steps on each pulse of an external 100 Hz tick, reloads itself each time it runs out, and restarts whenever software writes either timeout byte. The regular writes of a healthy program therefore keep it from expiring.

Every expiry raises a sticky watchdog flag, whether or not the watchdog is enabled. Two control bits decide what else happens. With the enable bit set and the steering bit clear, the flag is passed on as an interrupt request, and this repeats on every expiry. With both bits set, the block drives an active-low reset pulse of fixed length, then clears its own enable bit, so the reset fires only once. Writing zero to both timeout bytes stops the counter.

The control is a three-state machine. IDLE_HALT: the timeout is zero or has never been written, and the counter is frozen. COUNTING: the counter runs. RESET_PULSE: the reset output is low. Transitions: HALT→COUNTING on a timeout write with a nonzero result. COUNTING→HALT on a timeout write with a zero result. COUNTING→RESET_PULSE on an expiry while enable and steering are both 1. RESET_PULSE→COUNTING, or →HALT when the timeout is zero, once the pulse time has elapsed.

Top module: `bcd_wdog`

## Requirements
- R1: The timeout is N = 1000·T + 100·U + 10·t + h. The whole byte holds tens in bits 7:4 and units in bits 3:0. The fraction byte holds tenths in bits 7:4 and hundredths in bits 3:0. The first expiry comes exactly N ticks after the timeout is loaded, and every counter digit always stays in the range 0–9.
- R2: After an expiry the counter reloads by itself, so expiries repeat every N ticks without any new write.
- R3: A write to either timeout byte alone reloads the counter with the complete updated timeout and restarts the count. A write in the same cycle as a tick takes priority over that tick.
- R4: With both timeout bytes equal to 00h, no tick causes an expiry and the flag stays 0.
- R5: Every expiry sets wd_flag to 1, whatever the enable and steering bits hold.
- R6: wd_flag is cleared by a flag_clr strobe or by a status_rd strobe. When an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: When enable is 1 and steering is 0, irq_req is 1 whenever wd_flag is 1, on every expiry, and rst_out_n stays 1.
- R8: When enable is 1 and steering is 1, an expiry drives rst_out_n low from the clock edge that records the expiry, for exactly PULSE_CYCLES cycles. wd_enable reads 0 from the edge on which rst_out_n returns high, and irq_req stays 0 throughout.
- R9: After reset, wd_flag = 0, wd_enable = 0, steering = 0, irq_req = 0 and rst_out_n = 1. Ticks cause no expiry until a timeout byte is written.
- R10: A timeout write during the reset pulse is accepted. The next expiry then comes after the newly written count.
- R11: When enable is 0, an expiry sets only the flag: irq_req stays 0 and rst_out_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle strobe at 100 Hz |
| tmo_lo_we | input | 1 | Write strobe for the fraction byte (tenths, hundredths) |
| tmo_hi_we | input | 1 | Write strobe for the whole-seconds byte |
| wr_byte | input | 8 | BCD data for the timeout writes |
| ctl_we | input | 1 | Write strobe for the enable and steering bits |
| ctl_en | input | 1 | New enable bit |
| ctl_steer | input | 1 | New steering bit (0 interrupt, 1 reset) |
| flag_clr | input | 1 | Software write of 0 to the flag |
| status_rd | input | 1 | Status read strobe, clears the flag |
| wd_flag | output | 1 | Sticky watchdog flag |
| wd_enable | output | 1 | Current enable bit |
| irq_req | output | 1 | Interrupt request contribution, active high |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
The hardest case to reach is a timeout write that lands inside the reset pulse. It has to arrive after the expiry has already reloaded the counter with the old value, and before the machine leaves RESET_PULSE. The bench gets there by arming single-shot mode with a count of 3, giving exactly three ticks, and issuing the two byte writes of a count of 2 on the negative edges that follow, while the pulse (6 cycles in the bench) is still low. It then counts the ticks to the next expiry, which tells the new count apart from the old one. The same tick-counting probe also sweeps every timeout from 1 to 40, plus the values at each digit rollover.

// File: rtl/bcd_wdog_pkg.sv
package bcd_wdog_pkg;
    localparam int DIGIT_W   = 4;
    localparam int NUM_DIGIT = 4;
    localparam int TMO_W     = DIGIT_W * NUM_DIGIT;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/bcd_down_counter.sv
module bcd_down_counter #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [4*DIGITS-1:0] load_val,
    input  logic                step,
    output logic [4*DIGITS-1:0] value,
    output logic                at_one
);
    localparam int W = 4 * DIGITS;

    logic [DIGITS:0] borrow;
    assign borrow[0] = step;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        assign d = value[4*i +: 4];
        assign borrow[i+1] = borrow[i] & (d == 4'd0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value[4*i +: 4] <= 4'd0;
            end else if (load) begin
                value[4*i +: 4] <= load_val[4*i +: 4];
            end else if (borrow[i]) begin
                value[4*i +: 4] <= (d == 4'd0) ? 4'd9 : d - 4'd1;
            end
        end
    end

    assign at_one = (value == W'(1));
endmodule

// File: rtl/wd_pulse_timer.sv
module wd_pulse_timer #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CW'(PULSE_CYCLES - 1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = (remain_q == '0);
endmodule

// File: rtl/bcd_wdog.sv
module bcd_wdog
    import bcd_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tmo_lo_we,
    input  logic       tmo_hi_we,
    input  logic [7:0] wr_byte,
    input  logic       ctl_we,
    input  logic       ctl_en,
    input  logic       ctl_steer,
    input  logic       flag_clr,
    input  logic       status_rd,
    output logic       wd_flag,
    output logic       wd_enable,
    output logic       irq_req,
    output logic       rst_out_n
);
    localparam int HALF_W = TMO_W / 2;

    wd_state_e state_q, state_d;

    logic [HALF_W-1:0] tmo_lo_q, tmo_hi_q;
    logic [HALF_W-1:0] new_lo, new_hi;
    logic [TMO_W-1:0]  cur_tmo, new_tmo, cnt_val, load_val;
    logic              wr_any, counting, cnt_step, cnt_load, at_one, expire;
    logic              pulse_start, pulse_done;
    logic              en_q, steer_q, flag_q;

    // Timeout bytes: deliberately left without reset
    always_ff @(posedge clk) begin
        if (tmo_lo_we) tmo_lo_q <= wr_byte;
        if (tmo_hi_we) tmo_hi_q <= wr_byte;
    end

    assign wr_any   = tmo_lo_we | tmo_hi_we;
    assign new_lo   = tmo_lo_we ? wr_byte : tmo_lo_q;
    assign new_hi   = tmo_hi_we ? wr_byte : tmo_hi_q;
    assign new_tmo  = {new_hi, new_lo};
    assign cur_tmo  = {tmo_hi_q, tmo_lo_q};

    assign counting = (state_q != ST_HALT) && (cur_tmo != '0);
    assign cnt_step = counting & tick & ~wr_any;
    assign expire   = cnt_step & at_one;
    assign cnt_load = wr_any | expire;
    assign load_val = wr_any ? new_tmo : cur_tmo;

    bcd_down_counter #(.DIGITS(NUM_DIGIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .step     (cnt_step),
        .value    (cnt_val),
        .at_one   (at_one)
    );

    assign pulse_start = (state_q == ST_COUNT) && (state_d == ST_PULSE);

    wd_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .done  (pulse_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (wr_any && new_tmo != '0) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (wr_any && new_tmo == '0)        state_d = ST_HALT;
                else if (expire && en_q && steer_q) state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (pulse_done) state_d = (new_tmo != '0) ? ST_COUNT : ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // State and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            en_q    <= 1'b0;
            steer_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PULSE && pulse_done) en_q <= 1'b0;
            else if (ctl_we)                       en_q <= ctl_en;
            if (ctl_we) steer_q <= ctl_steer;
            if (expire)                      flag_q <= 1'b1;
            else if (flag_clr || status_rd)  flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        rst_out_n = (state_q != ST_PULSE);
        irq_req   = flag_q & en_q & ~steer_q;
        wd_flag   = flag_q;
        wd_enable = en_q;
    end
endmodule

// File: rtl/bcd_wdog_chk.sv
module bcd_wdog_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rst_out_n,
    input logic         wd_flag,
    input logic         flag_clr,
    input logic         status_rd,
    input logic         en_q,
    input logic         steer_q,
    input logic [W-1:0] cnt_val
);
    logic digits_ok;
    always_comb begin
        digits_ok = 1'b1;
        for (int i = 0; i < W / 4; i++) begin
            if (cnt_val[4*i +: 4] > 4'd9) digits_ok = 1'b0;
        end
    end

    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok); // R1
    AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_flag) |-> $past(flag_clr || status_rd)); // R6
    AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> $past(en_q && steer_q)); // R8
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> wd_flag); // R5
    AST_ENABLE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> !en_q); // R8
endmodule

bind bcd_wdog bcd_wdog_chk #(.W(bcd_wdog_pkg::TMO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_out_n),
    .wd_flag   (wd_flag),
    .flag_clr  (flag_clr),
    .status_rd (status_rd),
    .en_q      (en_q),
    .steer_q   (steer_q),
    .cnt_val   (cnt_val)
);

// File: tb/bcd_wdog_tb.sv
module bcd_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, tmo_lo_we = 0, tmo_hi_we = 0, ctl_we = 0, ctl_en = 0, ctl_steer = 0;
    logic flag_clr = 0, status_rd = 0;
    logic [7:0] wr_byte = '0;
    logic wd_flag, wd_enable, irq_req, rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_wdog #(.PULSE_CYCLES(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tmo_lo_we(tmo_lo_we),
        .tmo_hi_we(tmo_hi_we), .wr_byte(wr_byte), .ctl_we(ctl_we),
        .ctl_en(ctl_en), .ctl_steer(ctl_steer), .flag_clr(flag_clr),
        .status_rd(status_rd), .wd_flag(wd_flag), .wd_enable(wd_enable),
        .irq_req(irq_req), .rst_out_n(rst_out_n)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(int n);
        return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    task automatic wr_tmo(int n);
        logic [15:0] b = to_bcd(n);
        tmo_hi_we = 1; wr_byte = b[15:8];
        @(negedge clk) tmo_hi_we = 0; tmo_lo_we = 1; wr_byte = b[7:0];
        @(negedge clk) tmo_lo_we = 0;
    endtask

    task automatic do_tick();
        tick = 1;
        @(negedge clk) tick = 0;
    endtask

    task automatic rd_status();
        status_rd = 1;
        @(negedge clk) status_rd = 0;
    endtask

    task automatic set_ctl(logic en, logic st);
        ctl_we = 1; ctl_en = en; ctl_steer = st;
        @(negedge clk) ctl_we = 0;
    endtask

    // Ticks until the flag rises (0 if not within limit)
    task automatic measure(int limit, output int got);
        rd_status();
        got = 0;
        for (int k = 1; k <= limit; k++) begin
            do_tick();
            if (wd_flag) begin got = k; break; end
        end
    endtask

    initial begin
        int got, lowcnt;
        int vals[6] = '{99, 100, 101, 999, 1000, 1234};
        repeat (3) @(negedge clk);
        check("R9 flag", wd_flag, 0);
        check("R9 enable", wd_enable, 0);
        check("R9 irq", irq_req, 0);
        check("R9 rst_out_n", rst_out_n, 1);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) do_tick();
        check("R9 no expiry before write", wd_flag, 0);

        // R1 sweep, enable off
        set_ctl(0, 0);
        for (int n = 1; n <= 40; n++) begin
            wr_tmo(n);
            measure(n + 2, got);
            check("R1 ticks to expiry", got, n);
            check("R11 irq with enable off", irq_req, 0);
        end
        foreach (vals[i]) begin
            wr_tmo(vals[i]);
            measure(vals[i] + 2, got);
            check("R1 ticks to expiry", got, vals[i]);
            check("R5 flag set while disabled", wd_flag, 1);
        end

        // R2 repeated expiries
        wr_tmo(7);
        for (int r = 0; r < 3; r++) begin
            measure(9, got);
            check("R2 reload period", got, 7);
        end

        // R3 partial writes restart
        wr_tmo(10);
        for (int k = 0; k < 6; k++) do_tick();
        tmo_lo_we = 1; wr_byte = 8'h08;
        @(negedge clk) tmo_lo_we = 0;
        measure(12, got);
        check("R3 frac write restart", got, 8);
        for (int k = 0; k < 3; k++) do_tick();
        tmo_hi_we = 1; wr_byte = 8'h00; tick = 1;
        @(negedge clk) tmo_hi_we = 0; tick = 0;
        measure(12, got);
        check("R3 whole write restart, tick ignored", got, 8);

        // R4 zero timeout
        wr_tmo(0);
        rd_status();
        for (int k = 0; k < 50; k++) do_tick();
        check("R4 zero timeout no flag", wd_flag, 0);

        // R7 repetitive interrupt
        set_ctl(1, 0);
        wr_tmo(4);
        measure(6, got);
        check("R7 expiry", got, 4);
        check("R7 irq asserted", irq_req, 1);
        check("R7 rst_out_n high", rst_out_n, 1);
        rd_status();
        check("R6 status read clears flag", wd_flag, 0);
        check("R7 irq follows flag", irq_req, 0);
        for (int k = 0; k < 4; k++) do_tick();
        check("R7 irq repeats", irq_req, 1);
        flag_clr = 1;
        @(negedge clk) flag_clr = 0;
        check("R6 clear write", wd_flag, 0);

        // R6 set beats clear
        set_ctl(0, 0);
        wr_tmo(2);
        rd_status();
        do_tick();
        tick = 1; status_rd = 1;
        @(negedge clk) tick = 0; status_rd = 0;
        check("R6 set priority", wd_flag, 1);

        // R8 single-shot
        set_ctl(1, 1);
        wr_tmo(3);
        rd_status();
        for (int k = 0; k < 3; k++) do_tick();
        check("R8 rst_out_n low", rst_out_n, 0);
        check("R8 flag", wd_flag, 1);
        check("R8 irq low", irq_req, 0);
        lowcnt = 1;
        for (int k = 0; k < 3 * PULSE; k++) begin
            @(negedge clk);
            if (!rst_out_n) lowcnt++; else break;
        end
        check("R8 pulse length", lowcnt, PULSE);
        check("R8 enable cleared", wd_enable, 0);

        // R10 write during pulse
        set_ctl(1, 1);
        wr_tmo(3);
        rd_status();
        for (int k = 0; k < 3; k++) do_tick();
        check("R10 pulse started", rst_out_n, 0);
        wr_tmo(2);
        check("R10 pulse still low", rst_out_n, 0);
        for (int k = 0; k < 3 * PULSE; k++) if (!rst_out_n) @(negedge clk);
        check("R10 enable cleared", wd_enable, 0);
        measure(5, got);
        check("R10 new count used", got, 2);
        check("R11 no second pulse", rst_out_n, 1);
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule